// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block decides, at each instruction boundary of a processor core, whether an interrupt is taken and which entrance address the core jumps to. It collects requests from two groups. The first group is internal and cannot be blocked: power failure, power recovery, control error and five trapped-order codes. The second group is a set of external level lines. Each external line is gated by its own mask bit, and all of them are gated by one global block flag.

When the boundary strobe arrives, the controller picks the single highest-priority eligible request. On the next cycle it raises a one-cycle take pulse and presents a 15-bit entrance vector. The core uses that take cycle to insert the extra cycle that interrupt entry costs. Taking any interrupt sets the block flag and copies its previous value into a history bit. Internal requests that were not chosen are discarded. External lines are levels owned by their devices: they are never cleared here, so an unserved line keeps requesting.

Software loads the mask through a write port and reads it on an output. A read and a write in the same cycle form an exchange. A second write port sets or clears the block flag.

Top module: `pvic_top`

## Requirements
- R1: After reset, take_o is 0, vector_o is 0, block_o is 0, block_hist_o is 0 and mask_o is all zeros.
- R2: An eligible external line b raises take_o for exactly one cycle, in the cycle after the boundary strobe. vector_o is then EXT_W-1-b. With EXT_W=24, line 23 gives vector 0, line 16 gives 7 and line 0 gives 27 octal.
- R3: Among eligible external lines, the highest-numbered line wins. A lower line that loses stays requesting and is taken at a later boundary once the block flag is clear and the higher line has dropped.
- R4: An external line whose mask bit is 0 never causes a take. mask_wr_i loads mask_wdata_i into the mask, and mask_o shows the loaded value on the next cycle.
- R5: Every take sets block_o to 1 and copies the value block_o had before the take into block_hist_o. While block_o is 1, no external line is taken. blk_wr_i writes blk_wdata_i into the block flag.
- R6: Internal requests rank above all external lines and ignore the block flag. Their order, from highest, is power failure (vector 37 octal), power recovery (36), control error (35), then trap codes 4 down to 0. Trap code k gives vector 30+k octal. A trap pulse with a code of 5 to 7 is ignored.
- R7: When an interrupt is taken, every internal request that was pending and not chosen is discarded.
- R8: No take occurs without a boundary strobe. A boundary strobe that arrives while indirect_busy_i is 1 is ignored.
- R9: While inhibit_i is 1, internal requests are neither captured nor kept, and any already pending are cleared. External lines are unaffected by inhibit_i.
- R10: An external line that is still high after being taken is taken again at the next boundary after the block flag is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| indirect_busy_i | input | 1 | Indirect-address chain in progress; holds off entry |
| ext_req_i | input | EXT_W | External request levels |
| pwr_fail_i | input | 1 | Power-failure request pulse |
| pwr_recov_i | input | 1 | Power-recovery request pulse |
| ctl_err_i | input | 1 | Control-error request pulse |
| trap_i | input | 1 | Trapped-order request pulse |
| trap_code_i | input | 3 | Trap code qualifying trap_i (0..4 valid) |
| inhibit_i | input | 1 | Console override that suppresses all internal requests |
| mask_wr_i | input | 1 | Mask write enable |
| mask_wdata_i | input | EXT_W | New mask value |
| blk_wr_i | input | 1 | Block-flag write enable |
| blk_wdata_i | input | 1 | New block-flag value |
| mask_o | output | EXT_W | Current mask |
| block_o | output | 1 | Global external block flag |
| block_hist_o | output | 1 | Block flag value before the latest take |
| take_o | output | 1 | One-cycle take pulse |
| vector_o | output | 15 | Entrance address, valid with take_o |

## Verification
The assertions assume that the boundary strobe never falls in the same cycle as a mask or block-flag write. They also assume that trap_i is only meaningful together with its code. Under those assumptions they can tie a take to the strobe, to the mask and to the block flag of the previous cycle. The stimulus keeps to these assumptions: every register write and every request pulse is driven in cycles of its own, separated from the strobe by at least one clock. The bench sweeps each of the 24 external lines with and without its mask bit, every internal source alone and in priority pairs, and the hold-off and inhibit inputs.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
   localparam int VEC_W   = 15;
   localparam int TRAP_N  = 5;
   localparam int TRAP_CW = 3;
   localparam int INT_N   = 3 + TRAP_N;
   localparam logic [VEC_W-1:0] INT_BASE = 15'o30;

   typedef logic [VEC_W-1:0] vec_t;

   // packed order is priority order: bit INT_N-1 is the highest
   typedef struct packed {
      logic              pwr_fail;
      logic              pwr_recov;
      logic              ctl_err;
      logic [TRAP_N-1:0] trap;
   } int_req_t;
endpackage

// File: rtl/pvic_prio_enc.sv
module pvic_prio_enc #(
   parameter int W = 8,
   localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     req_i,
   output logic             hit_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      hit_o = 1'b0;
      idx_o = '0;
      for (int i = 0; i < W; i++) begin
         if (req_i[i]) begin
            hit_o = 1'b1;
            idx_o = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/pvic_int_src.sv
module pvic_int_src
   import pvic_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               inhibit_i,
   input  logic               clr_i,
   input  logic               pwr_fail_i,
   input  logic               pwr_recov_i,
   input  logic               ctl_err_i,
   input  logic               trap_i,
   input  logic [TRAP_CW-1:0] trap_code_i,
   output int_req_t           pend_o
);
   logic [TRAP_N-1:0] trap_hit;
   int_req_t          new_req;
   int_req_t          pend_q;

   for (genvar k = 0; k < TRAP_N; k++) begin : g_trap
      assign trap_hit[k] = trap_i && (trap_code_i == TRAP_CW'(k));
   end

   always_comb begin
      new_req.pwr_fail  = pwr_fail_i;
      new_req.pwr_recov = pwr_recov_i;
      new_req.ctl_err   = ctl_err_i;
      new_req.trap      = trap_hit;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni || inhibit_i) pend_q <= '0;
      else if (clr_i)           pend_q <= new_req;
      else                      pend_q <= pend_q | new_req;
   end

   assign pend_o = pend_q;
endmodule

// File: rtl/pvic_ctl.sv
module pvic_ctl #(
   parameter int EXT_W = 24
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             take_i,
   input  logic             blk_wr_i,
   input  logic             blk_wdata_i,
   input  logic             mask_wr_i,
   input  logic [EXT_W-1:0] mask_wdata_i,
   output logic [EXT_W-1:0] mask_o,
   output logic             block_o,
   output logic             hist_o
);
   logic [EXT_W-1:0] mask_q;
   logic             block_q, hist_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)        mask_q <= '0;
      else if (mask_wr_i) mask_q <= mask_wdata_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         block_q <= 1'b0;
         hist_q  <= 1'b0;
      end else if (take_i) begin
         block_q <= 1'b1;
         hist_q  <= block_q;
      end else if (blk_wr_i) begin
         block_q <= blk_wdata_i;
      end
   end

   assign mask_o  = mask_q;
   assign block_o = block_q;
   assign hist_o  = hist_q;
endmodule

// File: rtl/pvic_top.sv
module pvic_top
   import pvic_pkg::*;
#(
   parameter int EXT_W = 24
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               boundary_i,
   input  logic               indirect_busy_i,
   input  logic [EXT_W-1:0]   ext_req_i,
   input  logic               pwr_fail_i,
   input  logic               pwr_recov_i,
   input  logic               ctl_err_i,
   input  logic               trap_i,
   input  logic [TRAP_CW-1:0] trap_code_i,
   input  logic               inhibit_i,
   input  logic               mask_wr_i,
   input  logic [EXT_W-1:0]   mask_wdata_i,
   input  logic               blk_wr_i,
   input  logic               blk_wdata_i,
   output logic [EXT_W-1:0]   mask_o,
   output logic               block_o,
   output logic               block_hist_o,
   output logic               take_o,
   output logic [VEC_W-1:0]   vector_o
);
   localparam int EXT_IW = (EXT_W > 1) ? $clog2(EXT_W) : 1;
   localparam int INT_IW = $clog2(INT_N);

   if (EXT_W < 1 || EXT_W > 24) begin : g_bad_ext_w
      $error("pvic_top: EXT_W must be 1..24 so external vectors stay below the internal base");
   end

   int_req_t          pend;
   logic [INT_N-1:0]  int_act;
   logic [EXT_W-1:0]  ext_act;
   logic              int_hit, ext_hit, fire, take_d;
   logic [INT_IW-1:0] int_idx;
   logic [EXT_IW-1:0] ext_idx;
   vec_t              vec_d;
   logic              take_q;
   vec_t              vec_q;
   logic [EXT_W-1:0]  mask;
   logic              block;

   pvic_int_src u_src (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .inhibit_i   (inhibit_i),
      .clr_i       (take_d),
      .pwr_fail_i  (pwr_fail_i),
      .pwr_recov_i (pwr_recov_i),
      .ctl_err_i   (ctl_err_i),
      .trap_i      (trap_i),
      .trap_code_i (trap_code_i),
      .pend_o      (pend)
   );

   pvic_ctl #(.EXT_W(EXT_W)) u_ctl (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .take_i       (take_d),
      .blk_wr_i     (blk_wr_i),
      .blk_wdata_i  (blk_wdata_i),
      .mask_wr_i    (mask_wr_i),
      .mask_wdata_i (mask_wdata_i),
      .mask_o       (mask),
      .block_o      (block),
      .hist_o       (block_hist_o)
   );

   assign int_act = pend & {INT_N{~inhibit_i}};
   assign ext_act = ext_req_i & mask & {EXT_W{~block}};

   pvic_prio_enc #(.W(INT_N)) u_int_enc (
      .req_i (int_act),
      .hit_o (int_hit),
      .idx_o (int_idx)
   );

   pvic_prio_enc #(.W(EXT_W)) u_ext_enc (
      .req_i (ext_act),
      .hit_o (ext_hit),
      .idx_o (ext_idx)
   );

   assign fire   = boundary_i && !indirect_busy_i;
   assign take_d = fire && (int_hit || ext_hit);

   always_comb begin
      if (int_hit) vec_d = INT_BASE + VEC_W'(int_idx);
      else         vec_d = VEC_W'(EXT_W - 1) - VEC_W'(ext_idx);
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         take_q <= 1'b0;
         vec_q  <= '0;
      end else begin
         take_q <= take_d;
         if (take_d) vec_q <= vec_d;
      end
   end

   assign take_o   = take_q;
   assign vector_o = vec_q;
   assign mask_o   = mask;
   assign block_o  = block;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk
   import pvic_pkg::*;
#(
   parameter int EXT_W = 24
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             boundary_i,
   input logic             indirect_busy_i,
   input logic [EXT_W-1:0] mask_o,
   input logic             block_o,
   input logic             block_hist_o,
   input logic             take_o,
   input logic [VEC_W-1:0] vector_o
);
   logic [EXT_W-1:0] mask_prev;
   logic             block_prev;
   logic             is_ext;
   logic             line_on;
   int               line;

   always_ff @(posedge clk_i) begin
      mask_prev  <= mask_o;
      block_prev <= block_o;
   end

   always_comb begin
      is_ext  = vector_o < VEC_W'(EXT_W);
      line    = EXT_W - 1 - int'(vector_o);
      line_on = 1'b0;
      if (is_ext && line >= 0 && line < EXT_W) line_on = mask_prev[line];
   end

   AST_TAKE_NEEDS_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> $past(boundary_i && !indirect_busy_i)); // R8

   AST_TAKE_SETS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> block_o); // R5

   AST_HIST_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (block_hist_o == block_prev)); // R5

   AST_EXT_MASK_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_o && is_ext) |-> (line_on && !block_prev)); // R4

   AST_VEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_o |-> (is_ext || (vector_o >= 15'o30 && vector_o <= 15'o37))); // R6
endmodule

bind pvic_top pvic_chk #(.EXT_W(EXT_W)) u_chk (
   .clk_i           (clk_i),
   .rst_ni          (rst_ni),
   .boundary_i      (boundary_i),
   .indirect_busy_i (indirect_busy_i),
   .mask_o          (mask_o),
   .block_o         (block_o),
   .block_hist_o    (block_hist_o),
   .take_o          (take_o),
   .vector_o        (vector_o)
);

// File: tb/pvic_top_tb_top.sv
`timescale 1ns/1ps
module pvic_top_tb_top;
   localparam int EW = 24;

   logic          clk_i = 1'b0;
   logic          rst_ni = 1'b0;
   logic          boundary_i = 1'b0;
   logic          indirect_busy_i = 1'b0;
   logic [EW-1:0] ext_req_i = '0;
   logic          pwr_fail_i = 1'b0;
   logic          pwr_recov_i = 1'b0;
   logic          ctl_err_i = 1'b0;
   logic          trap_i = 1'b0;
   logic [2:0]    trap_code_i = '0;
   logic          inhibit_i = 1'b0;
   logic          mask_wr_i = 1'b0;
   logic [EW-1:0] mask_wdata_i = '0;
   logic          blk_wr_i = 1'b0;
   logic          blk_wdata_i = 1'b0;
   logic [EW-1:0] mask_o;
   logic          block_o, block_hist_o, take_o;
   logic [14:0]   vector_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk_i = ~clk_i;

   pvic_top #(.EXT_W(EW)) dut_i (.*);

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic strobe();
      @(negedge clk_i) boundary_i = 1'b1;
      @(negedge clk_i) boundary_i = 1'b0;
   endtask

   task automatic set_mask(input logic [EW-1:0] m);
      @(negedge clk_i) begin mask_wr_i = 1'b1; mask_wdata_i = m; end
      @(negedge clk_i) mask_wr_i = 1'b0;
   endtask

   task automatic set_block(input logic v);
      @(negedge clk_i) begin blk_wr_i = 1'b1; blk_wdata_i = v; end
      @(negedge clk_i) blk_wr_i = 1'b0;
   endtask

   task automatic pulse_int(input int which, input int code);
      @(negedge clk_i) begin
         case (which)
            0: pwr_fail_i = 1'b1;
            1: pwr_recov_i = 1'b1;
            2: ctl_err_i = 1'b1;
            default: begin trap_i = 1'b1; trap_code_i = 3'(code); end
         endcase
      end
      @(negedge clk_i) begin
         pwr_fail_i = 1'b0; pwr_recov_i = 1'b0; ctl_err_i = 1'b0; trap_i = 1'b0;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk_i);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk_i);
      rst_ni = 1'b1;
      @(negedge clk_i);
      check("R1 take", 32'(take_o), 0);
      check("R1 vector", 32'(vector_o), 0);
      check("R1 block", 32'(block_o), 0);
      check("R1 hist", 32'(block_hist_o), 0);
      check("R1 mask", 32'(mask_o), 0);

      // R2: every external line alone, full mask
      set_mask('1);
      check("R4 mask readback", 32'(mask_o), 32'(24'hFFFFFF));
      for (int b = 0; b < EW; b++) begin
         ext_req_i = EW'(1) << b;
         strobe();
         check("R2 take", 32'(take_o), 1);
         check("R2 vector", 32'(vector_o), 32'(EW - 1 - b));
         check("R5 block set", 32'(block_o), 1);
         check("R5 hist", 32'(block_hist_o), 0);
         @(negedge clk_i);
         check("R2 one cycle", 32'(take_o), 0);
         ext_req_i = '0;
         set_block(1'b0);
      end

      // R4: mask bit closed for the active line
      for (int b = 0; b < EW; b++) begin
         set_mask(~(EW'(1) << b));
         ext_req_i = EW'(1) << b;
         strobe();
         check("R4 masked no take", 32'(take_o), 0);
         ext_req_i = '0;
      end
      set_mask('1);

      // R5: block by write port, then internal take records hist=1
      set_block(1'b1);
      ext_req_i = EW'(1) << 10;
      strobe();
      check("R5 blocked ext", 32'(take_o), 0);
      pulse_int(0, 0);
      strobe();
      check("R6 pf ignores block", 32'(take_o), 1);
      check("R6 pf vector", 32'(vector_o), 32'o37);
      check("R5 hist one", 32'(block_hist_o), 1);
      ext_req_i = '0;
      set_block(1'b0);

      // R3: two lines, higher wins, lower later
      ext_req_i = (EW'(1) << 12) | (EW'(1) << 5);
      strobe();
      check("R3 higher wins", 32'(vector_o), 32'(EW - 1 - 12));
      ext_req_i = EW'(1) << 5;
      set_block(1'b0);
      strobe();
      check("R3 lower later take", 32'(take_o), 1);
      check("R3 lower later vector", 32'(vector_o), 32'(EW - 1 - 5));
      ext_req_i = '0;
      set_block(1'b0);

      // R10: level held is retaken
      ext_req_i = EW'(1) << 7;
      strobe();
      check("R10 first", 32'(vector_o), 16);
      set_block(1'b0);
      strobe();
      check("R10 again take", 32'(take_o), 1);
      check("R10 again vector", 32'(vector_o), 16);
      ext_req_i = '0;
      set_block(1'b0);

      // R6: each internal alone
      for (int s = 0; s < 3; s++) begin
         pulse_int(s, 0);
         strobe();
         check("R6 internal take", 32'(take_o), 1);
         check("R6 internal vector", 32'(vector_o), 32'(31 - s));
         set_block(1'b0);
      end
      for (int k = 0; k < 8; k++) begin
         pulse_int(3, k);
         strobe();
         check("R6 trap take", 32'(take_o), (k < 5) ? 1 : 0);
         if (k < 5) check("R6 trap vector", 32'(vector_o), 32'(24 + k));
         set_block(1'b0);
      end

      // R6: internal over external line 23
      ext_req_i = EW'(1) << 23;
      pulse_int(2, 0);
      strobe();
      check("R6 internal over ext", 32'(vector_o), 32'o35);
      ext_req_i = '0;
      set_block(1'b0);

      // R7: unserved internal discarded
      pulse_int(1, 0);
      pulse_int(0, 0);
      strobe();
      check("R7 pf first", 32'(vector_o), 32'o37);
      strobe();
      check("R7 pr discarded", 32'(take_o), 0);
      pulse_int(3, 0);
      pulse_int(3, 4);
      strobe();
      check("R7 T34 first", 32'(vector_o), 32'o34);
      strobe();
      check("R7 T30 discarded", 32'(take_o), 0);
      set_block(1'b0);

      // R8: no boundary, and hold-off while indirect busy
      ext_req_i = EW'(1) << 3;
      repeat (4) @(negedge clk_i);
      check("R8 no strobe", 32'(take_o), 0);
      indirect_busy_i = 1'b1;
      strobe();
      check("R8 busy hold", 32'(take_o), 0);
      indirect_busy_i = 1'b0;
      strobe();
      check("R8 after busy", 32'(vector_o), 32'(EW - 1 - 3));
      ext_req_i = '0;
      set_block(1'b0);

      // R9: inhibit
      inhibit_i = 1'b1;
      pulse_int(0, 0);
      strobe();
      check("R9 inhibited capture", 32'(take_o), 0);
      inhibit_i = 1'b0;
      pulse_int(1, 0);
      @(negedge clk_i) inhibit_i = 1'b1;
      @(negedge clk_i) inhibit_i = 1'b0;
      strobe();
      check("R9 pending cleared", 32'(take_o), 0);
      inhibit_i = 1'b1;
      ext_req_i = EW'(1) << 20;
      strobe();
      check("R9 ext unaffected", 32'(vector_o), 3);
      check("R9 ext take", 32'(take_o), 1);
      inhibit_i = 1'b0;
      ext_req_i = '0;

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule